// File: doc/BRIEF.md
# Range-Bypass Address Translator

This unit turns a 48-bit virtual address into a 41-bit physical address for a single process. Each request is checked at the same time against one linear segment, given by a lower bound, an upper bound and a displacement, and looked up in a small fully associative translation cache. When the address falls inside the segment, the result is the address minus the displacement. The cache result is then discarded, so such an address can never cause a translation miss or a page-table walk.

Addresses outside the segment use the cache. A cache hit gives the physical page directly. A miss holds the unit busy by dropping `req_ready` and presents the virtual page number to an external page-table walker. The walker answers with a fill. On that fill the entry is written into the cache, and the stalled access completes in the next cycle.

The bound and displacement registers can be read and written through a small configuration port. Software uses this port to save and restore them when it switches processes. Programming the upper bound at or below the lower bound turns the segment off, and every address then goes through paging.

Top module: `dseg_xlate`

## Requirements
- R1: Physical address bits 11..0 always equal virtual address bits 11..0. Only virtual bits 47..12 are translated into physical bits 40..12, and the low 12 bits of the displacement register are ignored.
- R2: An access is a segment hit when lower bound <= VA < upper bound, comparing all 48 bits. The result is then {(VA[47:12] - DISP[47:12])[28:0], VA[11:0]} with `rsp_from_seg` = 1.
- R3: An address equal to the lower bound is inside the segment. An address equal to the upper bound is outside it.
- R4: A segment hit never starts a walk, and it overrides a matching cache entry: the result comes from the segment even when the cache holds that page.
- R5: When the upper bound is less than or equal to the lower bound, no address is a segment hit.
- R6: A cache miss outside the segment raises `walk_req_valid` with `walk_req_vpn` = VA[47:12] in the cycle after acceptance. It holds `req_ready` low until a cycle with `fill_valid`. The next cycle then gives `rsp_valid` with {fill_ppn, VA[11:0]} and `rsp_from_seg` = 0, and `req_ready` returns high.
- R7: Segment hits and cache hits give `rsp_valid` exactly one cycle after acceptance. A cache hit returns the physical page number stored by the earlier fill, with `rsp_from_seg` = 0.
- R8: The cache holds 16 entries and replaces them round-robin. After 16 installs, the next install evicts the oldest entry, so a later access to that page misses again.
- R9: A write with `cfg_we` stores `cfg_wdata` into the register chosen by `cfg_sel` (0 lower bound, 1 upper bound, 2 displacement). `cfg_rdata` shows the chosen register from the next cycle on, and reads 0 for select 3.
- R10: After reset `req_ready` = 1, `rsp_valid` = 0, `walk_req_valid` = 0, all three registers read 0 (so the segment is off), and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_va | input | 48 | Virtual address |
| req_ready | output | 1 | Unit can accept a request |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | 41 | Physical address |
| rsp_from_seg | output | 1 | 1 = segment translation, 0 = paged |
| walk_req_valid | output | 1 | Walk requested (held until fill) |
| walk_req_vpn | output | 36 | Virtual page to walk |
| fill_valid | input | 1 | Walker response |
| fill_vpn | input | 36 | Virtual page of the fill |
| fill_ppn | input | 29 | Physical page of the fill |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 48 | Write data |
| cfg_rdata | output | 48 | Read data of selected register |

## Verification
The assertions check on every cycle that a segment hit is answered in the next cycle from the segment without a walk, and that an off segment never reports a hit. They also check that an outstanding walk keeps `req_ready` low and keeps its page number stable, and that no response appears without an acceptance or a fill in the cycle before it. Only the bench scenarios can show the arithmetic of the results, the exact bound edges, the override of a cached page, round-robin eviction after sixteen installs, and register read-back.

// File: rtl/dseg_pkg.sv
package dseg_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } xl_state_e;

    typedef enum logic [1:0] {
        SEL_LOWER = 2'd0,
        SEL_UPPER = 2'd1,
        SEL_DISP  = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/dseg_seg_check.sv
module dseg_seg_check #(
    parameter int VA_W = 48,
    parameter int PA_W = 41,
    parameter int PG_W = 12
) (
    input  logic [VA_W-1:0] va,
    input  logic [VA_W-1:0] lower,
    input  logic [VA_W-1:0] upper,
    input  logic [VA_W-1:0] disp,
    output logic            hit,
    output logic [PA_W-1:0] pa
);
    localparam int VPN_W = VA_W - PG_W;
    localparam int PPN_W = PA_W - PG_W;

    logic             enabled;
    logic [VPN_W-1:0] page_diff;

    always_comb begin
        enabled   = upper > lower;
        hit       = enabled && (va >= lower) && (va < upper);
        page_diff = va[VA_W-1:PG_W] - disp[VA_W-1:PG_W];
        pa        = {page_diff[PPN_W-1:0], va[PG_W-1:0]};
    end
endmodule

// File: rtl/dseg_tlb.sv
module dseg_tlb #(
    parameter int VPN_W = 36,
    parameter int PPN_W = 29,
    parameter int N     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [N-1:0]     valid_q, valid_d;
    logic [VPN_W-1:0] vpn_q [N];
    logic [VPN_W-1:0] vpn_d [N];
    logic [PPN_W-1:0] ppn_q [N];
    logic [PPN_W-1:0] ppn_d [N];
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic [N-1:0]     match;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = valid_q[i] && (vpn_q[i] == lk_vpn);
    end

    always_comb begin
        lk_hit = |match;
        lk_ppn = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) lk_ppn = lk_ppn | ppn_q[i];
        end
    end

    always_comb begin
        valid_d = valid_q;
        ptr_d   = ptr_q;
        for (int i = 0; i < N; i++) begin
            vpn_d[i] = vpn_q[i];
            ppn_d[i] = ppn_q[i];
        end
        if (fill_en) begin
            valid_d[ptr_q] = 1'b1;
            vpn_d[ptr_q]   = fill_vpn;
            ppn_d[ptr_q]   = fill_ppn;
            ptr_d          = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
            for (int i = 0; i < N; i++) begin
                vpn_q[i] <= '0;
                ppn_q[i] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            ptr_q   <= ptr_d;
            for (int i = 0; i < N; i++) begin
                vpn_q[i] <= vpn_d[i];
                ppn_q[i] <= ppn_d[i];
            end
        end
    end
endmodule

// File: rtl/dseg_xlate.sv
module dseg_xlate
    import dseg_pkg::*;
#(
    parameter int VA_W  = 48,
    parameter int PA_W  = 41,
    parameter int PG_W  = 12,
    parameter int TLB_N = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_va,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic [PA_W-1:0]      rsp_pa,
    output logic                 rsp_from_seg,
    output logic                 walk_req_valid,
    output logic [VA_W-PG_W-1:0] walk_req_vpn,
    input  logic                 fill_valid,
    input  logic [VA_W-PG_W-1:0] fill_vpn,
    input  logic [PA_W-PG_W-1:0] fill_ppn,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [VA_W-1:0]      cfg_wdata,
    output logic [VA_W-1:0]      cfg_rdata
);
    localparam int VPN_W = VA_W - PG_W;
    localparam int PPN_W = PA_W - PG_W;

    typedef struct packed {
        xl_state_e        st;
        logic [VA_W-1:0]  lower;
        logic [VA_W-1:0]  upper;
        logic [VA_W-1:0]  disp;
        logic [VPN_W-1:0] wvpn;
        logic [PG_W-1:0]  wpo;
        logic             rv;
        logic [PA_W-1:0]  pa;
        logic             fseg;
    } xl_regs_t;

    xl_regs_t q, d;

    logic             seg_hit;
    logic [PA_W-1:0]  seg_pa;
    logic             tlb_hit;
    logic [PPN_W-1:0] tlb_ppn;
    logic             accept;
    logic             fill_take;
    logic [VA_W-1:0]  cur_lower;
    logic [VA_W-1:0]  cur_upper;

    dseg_seg_check #(.VA_W(VA_W), .PA_W(PA_W), .PG_W(PG_W)) u_seg (
        .va    (req_va),
        .lower (q.lower),
        .upper (q.upper),
        .disp  (q.disp),
        .hit   (seg_hit),
        .pa    (seg_pa)
    );

    dseg_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .N(TLB_N)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (req_va[VA_W-1:PG_W]),
        .lk_hit   (tlb_hit),
        .lk_ppn   (tlb_ppn),
        .fill_en  (fill_take),
        .fill_vpn (fill_vpn),
        .fill_ppn (fill_ppn)
    );

    always_comb begin
        d         = q;
        d.rv      = 1'b0;
        accept    = req_valid && (q.st == ST_IDLE);
        fill_take = fill_valid && (q.st == ST_WALK);

        if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_LOWER: d.lower = cfg_wdata;
                SEL_UPPER: d.upper = cfg_wdata;
                SEL_DISP:  d.disp  = cfg_wdata;
                default:   ;
            endcase
        end

        if (accept) begin
            if (seg_hit) begin
                d.rv   = 1'b1;
                d.pa   = seg_pa;
                d.fseg = 1'b1;
            end else if (tlb_hit) begin
                d.rv   = 1'b1;
                d.pa   = {tlb_ppn, req_va[PG_W-1:0]};
                d.fseg = 1'b0;
            end else begin
                d.st   = ST_WALK;
                d.wvpn = req_va[VA_W-1:PG_W];
                d.wpo  = req_va[PG_W-1:0];
            end
        end

        if (fill_take) begin
            d.rv   = 1'b1;
            d.pa   = {fill_ppn, q.wpo};
            d.fseg = 1'b0;
            d.st   = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (cfg_sel_e'(cfg_sel))
            SEL_LOWER: cfg_rdata = q.lower;
            SEL_UPPER: cfg_rdata = q.upper;
            SEL_DISP:  cfg_rdata = q.disp;
            default:   cfg_rdata = '0;
        endcase
    end

    assign cur_lower      = q.lower;
    assign cur_upper      = q.upper;
    assign req_ready      = (q.st == ST_IDLE);
    assign walk_req_valid = (q.st == ST_WALK);
    assign walk_req_vpn   = q.wvpn;
    assign rsp_valid      = q.rv;
    assign rsp_pa         = q.pa;
    assign rsp_from_seg   = q.fseg;
endmodule

// File: rtl/dseg_xlate_chk.sv
module dseg_xlate_chk #(
    parameter int VA_W = 48,
    parameter int PG_W = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 rsp_valid,
    input logic                 rsp_from_seg,
    input logic                 walk_req_valid,
    input logic [VA_W-PG_W-1:0] walk_req_vpn,
    input logic                 fill_valid,
    input logic                 seg_hit,
    input logic [VA_W-1:0]      cur_lower,
    input logic [VA_W-1:0]      cur_upper
);
    AST_SEG_ANSWERS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && seg_hit) |=> (rsp_valid && rsp_from_seg && !walk_req_valid)); // R4

    AST_OFF_SEG_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_upper <= cur_lower) |-> !seg_hit); // R5

    AST_WALK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> !req_ready); // R6

    AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !fill_valid) |=> (walk_req_valid && $stable(walk_req_vpn))); // R6

    AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(fill_valid && walk_req_valid))); // R7
endmodule

bind dseg_xlate dseg_xlate_chk #(.VA_W(VA_W), .PG_W(PG_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .rsp_from_seg   (rsp_from_seg),
    .walk_req_valid (walk_req_valid),
    .walk_req_vpn   (walk_req_vpn),
    .fill_valid     (fill_valid),
    .seg_hit        (seg_hit),
    .cur_lower      (cur_lower),
    .cur_upper      (cur_upper)
);

// File: tb/sim_dseg_xlate.sv
module sim_dseg_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int TLB_N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [47:0] req_va = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [40:0] rsp_pa;
    logic        rsp_from_seg;
    logic        walk_req_valid;
    logic [35:0] walk_req_vpn;
    logic        fill_valid = 1'b0;
    logic [35:0] fill_vpn = '0;
    logic [28:0] fill_ppn = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [47:0] cfg_wdata = '0;
    logic [47:0] cfg_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    dseg_xlate u0 (.*);

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit running = 0;

    // reference state
    logic [47:0] m_lower = '0, m_upper = '0, m_disp = '0;
    logic [35:0] m_vpn[$];
    logic [28:0] m_ppn[$];
    bit          m_walking = 0;
    logic [35:0] m_wvpn = '0;
    bit          p_rv = 0;
    logic [40:0] p_pa = '0;
    bit          p_seg = 0;
    string       p_tag = "";

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [28:0] walker_ppn(input logic [35:0] vpn);
        return vpn[28:0] + 29'h0001_5A5;
    endfunction

    // per-cycle comparison against the reference, after outputs settle
    always @(posedge clk) begin
        if (running) begin
            #3;
            check(rsp_valid == p_rv, p_rv ? p_tag : "R7", "rsp_valid", 64'(rsp_valid), 64'(p_rv));
            if (p_rv) begin
                check(rsp_pa == p_pa, p_tag, "rsp_pa", 64'(rsp_pa), 64'(p_pa));
                check(rsp_from_seg == p_seg, p_tag, "rsp_from_seg", 64'(rsp_from_seg), 64'(p_seg));
            end
            check(walk_req_valid == m_walking, "R6", "walk_req_valid", 64'(walk_req_valid), 64'(m_walking));
            check(req_ready == !m_walking, "R6", "req_ready", 64'(req_ready), 64'(!m_walking));
            if (m_walking)
                check(walk_req_vpn == m_wvpn, "R6", "walk_req_vpn", 64'(walk_req_vpn), 64'(m_wvpn));
            p_rv = 0;
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [47:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        case (sel)
            2'd0: m_lower = val;
            2'd1: m_upper = val;
            2'd2: m_disp  = val;
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_rdata == ((sel == 2'd3) ? 48'h0 : val), "R9", "cfg_rdata after write",
              64'(cfg_rdata), 64'((sel == 2'd3) ? 48'h0 : val));
    endtask

    function automatic bit m_lookup(input logic [35:0] vpn, output logic [28:0] ppn);
        ppn = '0;
        foreach (m_vpn[i]) if (m_vpn[i] == vpn) begin ppn = m_ppn[i]; return 1; end
        return 0;
    endfunction

    // one access; tag names the requirement the result stands for
    task automatic access(input logic [47:0] va, input string tag, input int walk_delay = 2);
        logic [28:0] ppn;
        logic [35:0] vpn;
        logic [35:0] pdiff;
        bit in_seg;
        vpn = va[47:12];
        in_seg = (m_upper > m_lower) && (va >= m_lower) && (va < m_upper);
        @(negedge clk);
        req_valid = 1'b1; req_va = va;
        if (in_seg) begin
            pdiff = vpn - m_disp[47:12];
            p_rv = 1; p_pa = {pdiff[28:0], va[11:0]}; p_seg = 1; p_tag = tag;
        end else if (m_lookup(vpn, ppn)) begin
            p_rv = 1; p_pa = {ppn, va[11:0]}; p_seg = 0; p_tag = tag;
        end else begin
            m_walking = 1; m_wvpn = vpn;
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (m_walking) begin
            repeat (walk_delay) @(negedge clk);
            ppn = walker_ppn(vpn);
            fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
            m_walking = 0;
            p_rv = 1; p_pa = {ppn, va[11:0]}; p_seg = 0; p_tag = tag;
            if (m_vpn.size() == TLB_N) begin
                void'(m_vpn.pop_front());
                void'(m_ppn.pop_front());
            end
            m_vpn.push_back(vpn);
            m_ppn.push_back(ppn);
            @(negedge clk);
            fill_valid = 1'b0;
        end
    endtask

    // miss-or-hit probe: checks the unit's ready after one cycle
    task automatic expect_miss(input logic [47:0] va, input bit miss, input string tag);
        @(negedge clk);
        check(req_ready == 1'b1, tag, "ready before probe", 64'(req_ready), 64'd1);
        access(va, tag);
        check(1'b1, tag, "probe done", 64'd0, 64'd0);
        if (miss) ; // the per-cycle monitor already compared walk behaviour
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(req_ready == 1'b1, "R10", "req_ready", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R10", "rsp_valid", 64'(rsp_valid), 64'd0);
        check(walk_req_valid == 1'b0, "R10", "walk_req_valid", 64'(walk_req_valid), 64'd0);
        for (int s = 0; s < 4; s++) begin
            cfg_sel = 2'(s);
            #1;
            check(cfg_rdata == 48'h0, "R10", "register after reset", 64'(cfg_rdata), 64'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        running = 1;

        // R5 segment off after reset: everything walks
        access(48'h0000_0000_1234, "R5");
        // R9 register access
        cfg_write(2'd0, 48'h0000_4000_0000);
        cfg_write(2'd1, 48'h0000_8000_0000);
        cfg_write(2'd2, 48'hFFFF_3000_0ABC); // low bits nonzero, ignored (R1)
        cfg_write(2'd3, 48'h1234_5678_9ABC);
        cfg_sel = 2'd0; #1;
        check(cfg_rdata == 48'h0000_4000_0000, "R9", "lower read-back", 64'(cfg_rdata), 64'h4000_0000);
        cfg_sel = 2'd2; #1;
        check(cfg_rdata == 48'hFFFF_3000_0ABC, "R9", "disp read-back", 64'(cfg_rdata), 64'hFFFF_3000_0ABC);

        // R2 R1 R3 segment hits and edges
        access(48'h0000_4000_0000, "R3");
        access(48'h0000_5555_6789, "R2");
        access(48'h0000_7FFF_FFFF, "R3");
        access(48'h0000_8000_0000, "R3");   // at upper bound: walks
        access(48'h0000_3FFF_FFFF, "R3");   // just below lower: walks
        access(48'h0000_8000_0FED, "R7");   // cache hit, same page
        access(48'h0000_3FFF_F001, "R1");   // cache hit, new offset

        // R4 override: cache a page inside the range while segment is off
        cfg_write(2'd1, 48'h0000_4000_0000);   // upper == lower -> off (R5)
        access(48'h0000_6000_0111, "R5", 4);
        cfg_write(2'd1, 48'h0000_2000_0000);   // upper < lower -> off (R5)
        access(48'h0000_6000_0222, "R7");
        cfg_write(2'd1, 48'h0000_8000_0000);
        access(48'h0000_6000_0333, "R4");

        // R8 round-robin: 17 new pages, then revisit the oldest ones
        for (int p = 0; p < 17; p++) access(48'h0100_0000_0000 + 48'(p) * 48'h1000 + 48'h10, "R8", p % 3);
        access(48'h0100_0000_0020, "R8");   // first of the burst, evicted
        access(48'h0100_0000_2030, "R8");   // still present or evicted per order
        access(48'h0100_0001_0040, "R8");   // 17th page, present
        expect_miss(48'h0000_4000_0040, 0, "R2");

        repeat (3) @(negedge clk);
        running = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule